// File: doc/BRIEF.md
# Four-Bit Bidirectional Shift Register with Parallel Load

This block is a small register that holds a word and changes it on a clock edge in one of four ways, picked by a two-bit mode input. It can keep its value, move every bit one place toward the most significant end, move every bit one place toward the least significant end, or take a fresh word from a parallel input. Each flip-flop gets its next value from its own four-way selector. That selector picks between the bit's own value, the bit on each side of it, and the matching parallel data bit.

A separate serial input feeds each shift direction. The bit that enters at the least significant end on an upward shift comes from one input. The bit that enters at the most significant end on a downward shift comes from the other. The two end bits of the register also leave the block as serial outputs, next to the full parallel word. A synchronous active-high reset clears the word.

Top module: `bidirShiftReg`

## Requirements
- R1: With mode code 2'b00 (hold), the stored word does not change on a clock edge, whatever the data and serial inputs are.
- R2: With mode code 2'b01 (shift up), the next word is {q[2:0], serInUp}. Bit i+1 takes the old bit i, and bit 0 takes serInUp.
- R3: With mode code 2'b10 (shift down), the next word is {serInDown, q[3:1]}. Bit i takes the old bit i+1, and bit 3 takes serInDown.
- R4: With mode code 2'b11 (load), the next word equals parIn.
- R5: Shifting up with serInUp=0 doubles the value (4'b0100 becomes 4'b1000). Shifting down with serInDown=0 halves it (4'b0100 becomes 4'b0010).
- R6: When rst is 1 at a clock edge, the word becomes 4'b0000 whatever the mode code is.
- R7: serOutHigh always equals q[3] and serOutLow always equals q[0], in the same cycle as the parallel output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| parIn | input | 4 | Parallel load word |
| serInUp | input | 1 | Bit entering bit 0 on a shift up |
| serInDown | input | 1 | Bit entering bit 3 on a shift down |
| q | output | 4 | Parallel register contents |
| serOutHigh | output | 1 | Most significant bit of q |
| serOutLow | output | 1 | Least significant bit of q |

## Verification
All state sits directly on q, so a wrong next value shows at the ports one edge after the operation that caused it. A selector leg wired to the wrong neighbour shows on the first shift in that direction that moves a 1 across the faulty stage. An end stage that takes the wrong serial bit shows when that serial input differs from the bit that leaves at the other end. A hold that leaks shows after one edge with mode 00 and inputs that differ from the stored word.

// File: rtl/bidirShiftPkg.sv
package bidirShiftPkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } modeT;

  typedef struct packed {
    logic clear;
    logic [1:0] pick;
  } strobeT;
endpackage

// File: rtl/bidirShiftCtrl.sv
module bidirShiftCtrl
  import bidirShiftPkg::*;
(
  input  logic       rst,
  input  logic [1:0] mode,
  output strobeT     strobes
);
  always_comb begin
    strobes.clear = rst;
    unique case (modeT'(mode))
      MODE_HOLD: strobes.pick = 2'd0;
      MODE_UP:   strobes.pick = 2'd1;
      MODE_DOWN: strobes.pick = 2'd2;
      default:   strobes.pick = 2'd3;
    endcase
  end
endmodule

// File: rtl/bidirShiftPath.sv
module bidirShiftPath
  import bidirShiftPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  strobeT           strobes,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serInUp,
  input  logic             serInDown,
  output logic [WIDTH-1:0] q
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nextQ;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : gStage
      logic lowerNb;
      logic upperNb;
      if (gi == 0) begin : gLow
        assign lowerNb = serInUp;
      end else begin : gLowMid
        assign lowerNb = q[gi-1];
      end
      if (gi == TOP) begin : gHigh
        assign upperNb = serInDown;
      end else begin : gHighMid
        assign upperNb = q[gi+1];
      end
      always_comb begin
        unique case (strobes.pick)
          2'd0:    nextQ[gi] = q[gi];
          2'd1:    nextQ[gi] = lowerNb;
          2'd2:    nextQ[gi] = upperNb;
          default: nextQ[gi] = parIn[gi];
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.clear) q <= '0;
    else q <= nextQ;
  end

  // R6
  reset_clears_chk: assert property (@(posedge clk)
    strobes.clear |=> (q == '0));
  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.pick == 2'd0) |=> $stable(q));
  // R2
  shift_up_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.pick == 2'd1) |=> (q == {$past(q[TOP-1:0]), $past(serInUp)}));
  // R3
  shift_down_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.pick == 2'd2) |=> (q == {$past(serInDown), $past(q[TOP:1])}));
  // R4
  load_word_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.pick == 2'd3) |=> (q == $past(parIn)));
endmodule

// File: rtl/bidirShiftReg.sv
module bidirShiftReg
  import bidirShiftPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serInUp,
  input  logic             serInDown,
  output logic [WIDTH-1:0] q,
  output logic             serOutHigh,
  output logic             serOutLow
);
  strobeT strobes;

  bidirShiftCtrl ctrl (
    .rst(rst), .mode(mode), .strobes(strobes)
  );

  bidirShiftPath #(.WIDTH(WIDTH)) path (
    .clk(clk), .strobes(strobes), .parIn(parIn),
    .serInUp(serInUp), .serInDown(serInDown), .q(q)
  );

  assign serOutHigh = q[WIDTH-1];
  assign serOutLow  = q[0];

  // R7
  serial_ends_chk: assert property (@(posedge clk)
    (serOutHigh == q[WIDTH-1]) && (serOutLow == q[0]));
endmodule

// File: tb/bidirShiftReg_test.sv
module bidirShiftReg_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 10;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] mode;
  logic [3:0] parIn;
  logic serInUp, serInDown;
  logic [3:0] q;
  logic serOutHigh, serOutLow;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidirShiftReg uut (
    .clk(clk), .rst(rst), .mode(mode), .parIn(parIn),
    .serInUp(serInUp), .serInDown(serInDown),
    .q(q), .serOutHigh(serOutHigh), .serOutLow(serOutLow)
  );

  // vector: mode, parIn, serInUp, serInDown, expected q
  typedef struct packed {
    logic [1:0] m;
    logic [3:0] d;
    logic su;
    logic sd;
    logic [3:0] exp;
  } vecT;

  localparam vecT VECS [NVEC] = '{
    '{2'b11, 4'b0100, 1'b1, 1'b1, 4'b0100}, // R4 load
    '{2'b01, 4'b1111, 1'b0, 1'b1, 4'b1000}, // R5 double
    '{2'b11, 4'b0100, 1'b0, 1'b0, 4'b0100}, // R4
    '{2'b10, 4'b0000, 1'b1, 1'b0, 4'b0010}, // R5 halve
    '{2'b00, 4'b1101, 1'b1, 1'b1, 4'b0010}, // R1 hold
    '{2'b01, 4'b0000, 1'b1, 1'b0, 4'b0101}, // R2 serial up
    '{2'b01, 4'b0000, 1'b0, 1'b1, 4'b1010}, // R2
    '{2'b10, 4'b1111, 1'b0, 1'b1, 4'b1101}, // R3 serial down
    '{2'b10, 4'b0000, 1'b1, 1'b0, 4'b0110}, // R3
    '{2'b00, 4'b1001, 1'b0, 1'b0, 4'b0110}  // R1
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [1:0] m, input logic [3:0] d,
                      input logic su, input logic sd);
    rst = r; mode = m; parIn = d; serInUp = su; serInDown = sd;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    rst = 1'b1; mode = 2'b00; parIn = '0; serInUp = 0; serInDown = 0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R6", q, 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      step(1'b0, VECS[i].m, VECS[i].d, VECS[i].su, VECS[i].sd);
      check($sformatf("vector %0d", i), q, VECS[i].exp);
      check("R7", {serOutHigh, serOutLow}, {VECS[i].exp[3], VECS[i].exp[0]});
    end

    // R6 reset overrides load
    step(1'b0, 2'b11, 4'b1111, 0, 0);
    step(1'b1, 2'b11, 4'b1010, 1, 1);
    check("R6", q, 4'b0000);
    // R1 long hold with busy inputs
    step(1'b0, 2'b11, 4'b1001, 0, 0);
    for (int k = 0; k < 3; k++) step(1'b0, 2'b00, 4'(k * 5), 1, 1);
    check("R1", q, 4'b1001);
    // R2 ones shifted fully through
    for (int k = 0; k < 4; k++) step(1'b0, 2'b01, 4'b0000, 1, 0);
    check("R2", q, 4'b1111);
    // R3 zeros shifted fully through
    for (int k = 0; k < 4; k++) step(1'b0, 2'b10, 4'b1111, 1, 0);
    check("R3", q, 4'b0000);
    check("R7", {serOutHigh, serOutLow}, 2'b00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule